// File: doc/BRIEF.md
# Buck Gate Drive Sequencer

This block is the digital switching core of a synchronous buck converter. A fast clock is divided into switching periods of an even number of ticks. At the start of every period a PWM latch asks for the high-side switch. The latch drops its request when the external PWM comparator trips. The block turns that request into two registered gate enables, one for the high-side switch and one for the low-side switch. A non-overlap interlock makes sure the two enables are never high together and inserts a programmable dead time between them.

Two start-up and high-duty rules sit on top of this. The low-side enable stays blocked after reset or disable until the high side has been requested at least once, or until the soft-start-complete flag is high. This keeps the converter from discharging a pre-biased output. If the high-side request stays on for ON_LIMIT whole periods in a row, the latch is cleared at the midpoint of that last period. The low side then conducts for the rest of the period, which recharges the bootstrap capacitor. A thermal-trip input or a low enable forces both gates off.

Top module: `buck_gate_seq`

## Requirements
- R1: While rst_n is low and on the first edge after its release, gh_o and gl_o are low; the tick counter restarts at tick 0 when reset is released.
- R2: The high-side request is set for tick 0 of a period when cmp_trip_i is low on the last tick of the previous period, and stays clear for the whole period when cmp_trip_i is high there (0 % duty). It clears on the edge after cmp_trip_i is seen high and stays clear until the next period.
- R3: While cmp_trip_i stays low, the request stays high across whole periods (100 % duty) until the watchdog of R4 acts.
- R4: When the request has been high for ON_LIMIT-1 complete periods in a row, it clears at tick PERIOD_TICKS/2 of the next period. The run count restarts from zero on any cycle where the request is low or the block is not running.
- R5: After the forced clear of R4, gl_o rises within the same period once the dead time has elapsed, and it stays high until the next period starts.
- R6: Since the last reset, disable or thermal trip, gl_o stays low until the high-side request has been high at least once or ss_done_i has been seen high.
- R7: A gate output rises only when the opposite output was low on the previous edge and had been low for at least dead_cfg_i further cycles. With dead_cfg_i = 0 there is exactly one cycle with both gates low.
- R8: gh_o and gl_o are never high in the same cycle.
- R9: therm_trip_i high drives both gates low on the next edge. It also clears the start-up permission of R6 and the run count of R4.
- R10: enable_i low has the same effect as R9.
- R11: With SW_SENSE_EN = 1, gl_o can rise only on an edge where sw_high_i is low (switch node not high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Converter enable; low forces both gates off |
| cmp_trip_i | input | 1 | PWM comparator output; high ends the on-time |
| ss_done_i | input | 1 | Soft-start voltage has passed its completion threshold |
| therm_trip_i | input | 1 | Over-temperature trip; high forces both gates off |
| sw_high_i | input | 1 | Switch-node feedback, high while the node is up |
| dead_cfg_i | input | DT_W | Extra dead-time ticks between the fall of one gate and the rise of the other |
| gh_o | output | 1 | High-side gate enable |
| gl_o | output | 1 | Low-side gate enable |

## Verification
The bench drives full-on stretches long enough to reach the ON_LIMIT-th period. A watchdog that counts ticks instead of periods, or one that fires a period late, would show up as a shifted or missing low-side pulse at mid-period. Start-up with the soft-start flag low and a comparator stuck high checks that the low side stays blocked. A design that arms it at reset would pull the output down. Dead-time settings of zero and full scale, switch-node feedback held high, and thermal or enable drops in the middle of a pulse all target the interlock. Any overlap, or a gate that rises too soon after the other falls, is reported on the cycle it happens.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
   localparam int GATE_HI = 0;
   localparam int GATE_LO = 1;
   localparam int GATE_N  = 2;

   function automatic int opposite_gate(input int g);
      return (GATE_N - 1) - g;
   endfunction
endpackage

// File: rtl/bsq_phase_timer.sv
module bsq_phase_timer #(
   parameter int PERIOD_TICKS = 16,
   localparam int PH_W = $clog2(PERIOD_TICKS)
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [PH_W-1:0] phase_o,
   output logic            last_tick_o,
   output logic            mid_pre_o
);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD_TICKS - 1);
   localparam logic [PH_W-1:0] PH_MIDP = PH_W'(PERIOD_TICKS / 2 - 1);

   logic [PH_W-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                phase_q <= '0;
      else if (phase_q == PH_LAST) phase_q <= '0;
      else                       phase_q <= phase_q + 1'b1;
   end

   assign phase_o     = phase_q;
   assign last_tick_o = (phase_q == PH_LAST);
   assign mid_pre_o   = (phase_q == PH_MIDP);

   a_r1_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      last_tick_o |=> (phase_o == '0));
endmodule

// File: rtl/bsq_pwm_core.sv
module bsq_pwm_core #(
   parameter int ON_LIMIT = 20,
   localparam int CNT_W = $clog2(ON_LIMIT)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic last_tick_i,
   input  logic mid_pre_i,
   input  logic cmp_trip_i,
   input  logic ss_done_i,
   output logic pwm_o,
   output logic armed_o
);
   localparam logic [CNT_W-1:0] RUN_TOP = CNT_W'(ON_LIMIT - 1);

   logic             pwm_q, armed_q;
   logic [CNT_W-1:0] run_cnt_q;
   logic             force_clr;

   assign force_clr = (run_cnt_q == RUN_TOP) && mid_pre_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               pwm_q <= 1'b0;
      else if (!run_i)          pwm_q <= 1'b0;
      else if (last_tick_i)     pwm_q <= !cmp_trip_i;
      else if (cmp_trip_i || force_clr) pwm_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 run_cnt_q <= '0;
      else if (!run_i || !pwm_q)                  run_cnt_q <= '0;
      else if (last_tick_i && run_cnt_q != RUN_TOP) run_cnt_q <= run_cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= run_i && (armed_q || pwm_q || ss_done_i);
   end

   assign pwm_o   = pwm_q;
   assign armed_o = armed_q;

   a_r4_force_mid: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cnt_q == RUN_TOP && mid_pre_i) |=> !pwm_o);
   a_r4_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_o |=> (run_cnt_q == '0));
   a_r9_disarm: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (!armed_o && !pwm_o));
endmodule

// File: rtl/bsq_gate_lane.sv
module bsq_gate_lane #(
   parameter int DT_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_i,
   input  logic            other_on_i,
   input  logic [DT_W-1:0] other_low_cnt_i,
   input  logic [DT_W-1:0] dead_cfg_i,
   output logic            on_o,
   output logic [DT_W-1:0] low_cnt_o
);
   localparam logic [DT_W-1:0] CNT_MAX = '1;

   logic            on_q, permit;
   logic [DT_W-1:0] low_cnt_q;

   assign permit = req_i && !other_on_i && (other_low_cnt_i >= dead_cfg_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) on_q <= 1'b0;
      else        on_q <= permit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 low_cnt_q <= CNT_MAX;
      else if (on_q)              low_cnt_q <= '0;
      else if (low_cnt_q != CNT_MAX) low_cnt_q <= low_cnt_q + 1'b1;
   end

   assign on_o      = on_q;
   assign low_cnt_o = low_cnt_q;

   a_r7_other_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(on_o) |-> !$past(other_on_i));
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq #(
   parameter int PERIOD_TICKS = 16,
   parameter int ON_LIMIT     = 20,
   parameter int DT_W         = 4,
   parameter bit SW_SENSE_EN  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable_i,
   input  logic            cmp_trip_i,
   input  logic            ss_done_i,
   input  logic            therm_trip_i,
   input  logic            sw_high_i,
   input  logic [DT_W-1:0] dead_cfg_i,
   output logic            gh_o,
   output logic            gl_o
);
   import bsq_pkg::*;

   localparam int PH_W = $clog2(PERIOD_TICKS);

   generate
      if (PERIOD_TICKS < 4 || (PERIOD_TICKS % 2) != 0) begin : g_bad_period
         $error("PERIOD_TICKS must be even and at least 4");
      end
      if (ON_LIMIT < 2) begin : g_bad_limit
         $error("ON_LIMIT must be at least 2");
      end
      if (DT_W < 1) begin : g_bad_dt
         $error("DT_W must be at least 1");
      end
   endgenerate

   logic            run;
   logic [PH_W-1:0] phase;
   logic            last_tick, mid_pre;
   logic            pwm_q, armed_q;
   logic            lo_sense_ok;
   logic            gate_req [GATE_N];
   logic            gate_on  [GATE_N];
   logic [DT_W-1:0] low_cnt  [GATE_N];
   logic            phase_unused;

   assign run          = enable_i && !therm_trip_i;
   assign phase_unused = ^phase;

   bsq_phase_timer #(.PERIOD_TICKS(PERIOD_TICKS)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase_o     (phase),
      .last_tick_o (last_tick),
      .mid_pre_o   (mid_pre)
   );

   bsq_pwm_core #(.ON_LIMIT(ON_LIMIT)) u_pwm (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (run),
      .last_tick_i (last_tick),
      .mid_pre_i   (mid_pre),
      .cmp_trip_i  (cmp_trip_i),
      .ss_done_i   (ss_done_i),
      .pwm_o       (pwm_q),
      .armed_o     (armed_q)
   );

   generate
      if (SW_SENSE_EN) begin : g_sense
         assign lo_sense_ok = !sw_high_i;
      end else begin : g_nosense
         logic sense_unused;
         assign sense_unused = sw_high_i;
         assign lo_sense_ok  = 1'b1;
      end
   endgenerate

   assign gate_req[GATE_HI] = run && pwm_q;
   assign gate_req[GATE_LO] = run && armed_q && !pwm_q && lo_sense_ok;

   generate
      for (genvar g = 0; g < GATE_N; g++) begin : g_lane
         localparam int OTHER = opposite_gate(g);
         bsq_gate_lane #(.DT_W(DT_W)) u_lane (
            .clk             (clk),
            .rst_n           (rst_n),
            .req_i           (gate_req[g]),
            .other_on_i      (gate_on[OTHER]),
            .other_low_cnt_i (low_cnt[OTHER]),
            .dead_cfg_i      (dead_cfg_i),
            .on_o            (gate_on[g]),
            .low_cnt_o       (low_cnt[g])
         );
      end
   endgenerate

   assign gh_o = gate_on[GATE_HI];
   assign gl_o = gate_on[GATE_LO];

   a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(gh_o && gl_o));
   a_r9_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
      therm_trip_i |=> (!gh_o && !gl_o));
   a_r10_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> (!gh_o && !gl_o));
   a_r6_low_armed: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gl_o) |-> $past(armed_q));
   a_r11_sense: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gl_o) |-> !$past(sw_high_i));
   a_r7_break_before: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gh_o) |-> !$past(gl_o));
endmodule

// File: tb/test_buck_gate_seq.sv
`timescale 1ns/1ps
module test_buck_gate_seq;
   localparam int P  = 16;
   localparam int L  = 20;
   localparam int DW = 4;
   localparam int CMAX = (1 << DW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, cmp = 1'b1, ss = 1'b0, therm = 1'b0, sw = 1'b0;
   logic [DW-1:0] dead = '0;
   logic gh, gl;

   int nchk = 0, nfail = 0, cyc = 0;
   string cur_req = "R1";
   bit cmp_on = 1'b0;

   int m_ph = 0, m_on = 0, m_ghlow = CMAX, m_gllow = CMAX;
   bit m_pwm = 0, m_arm = 0, m_gh = 0, m_gl = 0;

   always #4 clk = ~clk;

   buck_gate_seq #(.PERIOD_TICKS(P), .ON_LIMIT(L), .DT_W(DW), .SW_SENSE_EN(1'b1)) i_buck_gate_seq (
      .clk(clk), .rst_n(rst_n), .enable_i(en), .cmp_trip_i(cmp), .ss_done_i(ss),
      .therm_trip_i(therm), .sw_high_i(sw), .dead_cfg_i(dead), .gh_o(gh), .gl_o(gl)
   );

   task automatic chk(input string req, input logic act, input logic exp, input string what);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // reference model, updated on every rising edge
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_ph = 0; m_pwm = 0; m_on = 0; m_arm = 0;
         m_gh = 0; m_gl = 0; m_ghlow = CMAX; m_gllow = CMAX;
      end else begin
         bit run, frc, lo_req, hi_req, n_pwm, n_arm, n_gh, n_gl;
         int n_on;
         run = en && !therm;
         frc = (m_on == L - 1) && (m_ph == P / 2 - 1);
         if (!run) n_pwm = 0;
         else if (m_ph == P - 1) n_pwm = !cmp;
         else if (cmp || frc) n_pwm = 0;
         else n_pwm = m_pwm;
         if (!run || !m_pwm) n_on = 0;
         else if (m_ph == P - 1 && m_on < L - 1) n_on = m_on + 1;
         else n_on = m_on;
         n_arm  = run && (m_arm || m_pwm || ss);
         hi_req = run && m_pwm;
         lo_req = run && m_arm && !m_pwm && !sw;
         n_gh = hi_req && !m_gl && (m_gllow >= int'(dead));
         n_gl = lo_req && !m_gh && (m_ghlow >= int'(dead));
         m_ghlow = m_gh ? 0 : (m_ghlow < CMAX ? m_ghlow + 1 : CMAX);
         m_gllow = m_gl ? 0 : (m_gllow < CMAX ? m_gllow + 1 : CMAX);
         m_ph  = (m_ph == P - 1) ? 0 : m_ph + 1;
         m_pwm = n_pwm; m_on = n_on; m_arm = n_arm; m_gh = n_gh; m_gl = n_gl;
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         chk(cur_req, gh, m_gh, "gh_o vs model");
         chk(cur_req, gl, m_gl, "gl_o vs model");
         chk("R8", gh && gl, 1'b0, "overlap");
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         nfail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   int gl_seen, gh_seen;

   task automatic run_duty(input int duty, input int cycles);
      repeat (cycles) begin
         @(negedge clk);
         if (duty <= 0) cmp = 1'b1;
         else if (duty >= P) cmp = 1'b0;
         else cmp = (m_ph >= duty) && (m_ph != P - 1);
         if (gl) gl_seen++;
         if (gh) gh_seen++;
      end
   endtask

   initial begin
      cur_req = "R1";
      repeat (4) begin
         @(negedge clk);
         chk("R1", gh, 1'b0, "gh_o in reset");
         chk("R1", gl, 1'b0, "gl_o in reset");
      end
      cmp_on = 1'b1;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", gh, 1'b0, "gh_o after release");
      chk("R1", gl, 1'b0, "gl_o after release");

      // R6: 0 % duty, no soft-start flag: low side must stay blocked
      cur_req = "R6"; en = 1'b1; dead = 4'd2;
      gl_seen = 0; gh_seen = 0;
      run_duty(0, 3 * P);
      chk("R6", gl_seen != 0, 1'b0, "gl_o while unarmed");
      chk("R2", gh_seen != 0, 1'b0, "gh_o at 0% duty");

      // R2: several duty ratios
      cur_req = "R2";
      run_duty(6, 3 * P);
      run_duty(11, 3 * P);
      run_duty(1, 3 * P);

      // R7: dead-time extremes
      cur_req = "R7"; dead = 4'd0; run_duty(8, 3 * P);
      dead = 4'd15; run_duty(8, 4 * P);
      dead = 4'd3;  run_duty(5, 3 * P);

      // R3, R4, R5: full-on run through the watchdog
      cur_req = "R4"; dead = 4'd2;
      run_duty(P, 4 * P);
      cur_req = "R3";
      gh_seen = 0; run_duty(P, 10 * P);
      chk("R3", gh_seen >= 10 * P - 2, 1'b1, "gh_o held at 100% duty");
      cur_req = "R5"; gl_seen = 0;
      run_duty(P, 10 * P);
      chk("R5", gl_seen != 0, 1'b1, "bootstrap refresh low pulse");
      cur_req = "R4";
      run_duty(P, 22 * P);

      // R11: switch node held high blocks low side
      cur_req = "R11"; sw = 1'b1; gl_seen = 0;
      run_duty(8, 3 * P);
      chk("R11", gl_seen != 0, 1'b0, "gl_o with node high");
      sw = 1'b0; run_duty(8, 2 * P);

      // R9: thermal trip mid pulse
      cur_req = "R9";
      run_duty(P, 3);
      @(negedge clk); therm = 1'b1;
      @(negedge clk);
      chk("R9", gh, 1'b0, "gh_o after trip");
      chk("R9", gl, 1'b0, "gl_o after trip");
      run_duty(8, 20);
      therm = 1'b0; gl_seen = 0;
      run_duty(0, 3 * P);
      chk("R9", gl_seen != 0, 1'b0, "gl_o disarmed after trip");

      // R10: enable drop, then soft-start flag arms the low side
      cur_req = "R10";
      run_duty(8, 2 * P + 5);
      @(negedge clk); en = 1'b0;
      @(negedge clk);
      chk("R10", gh, 1'b0, "gh_o after disable");
      chk("R10", gl, 1'b0, "gl_o after disable");
      run_duty(8, 20);
      en = 1'b1;
      cur_req = "R6"; ss = 1'b1; gl_seen = 0;
      run_duty(0, 2 * P);
      chk("R6", gl_seen != 0, 1'b1, "gl_o armed by soft-start flag");
      run_duty(7, 2 * P);

      cmp_on = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule